// File: doc/BRIEF.md
# Serial Frame Buffer Status Tracker

This block holds the buffer-related status of a serial frame link controller whose receiver is double-buffered: one buffer is filled from the bus, and the other is held for the CPU. Single-cycle event pulses from the bus engine drive three small state machines:

- a transmit tracker with states `TX_IDLE` and `TX_SENDING`;
- a receive tracker with states `RX_IDLE` and `RX_ACTIVE`;
- a buffer occupancy machine with states `BUF_EMPTY`, `BUF_BUS`, `BUF_CPU` and `BUF_BOTH`.

A separate sticky flag records lost data.

The result is a 16-bit read-only status word. The block also gives a same-cycle write enable for the bus-side buffer, and a swap acknowledge that tells the storage to exchange the two buffers. In normal mode a whole frame is the unit of arrival. In block mode each byte is a unit of arrival. An overwrite setting decides whether data that arrives at a full bus-side buffer replaces its contents or is dropped.

Transitions:

| Machine | Transition | Condition |
|---|---|---|
| Transmit | `TX_IDLE` to `TX_SENDING` | transmit start |
| Transmit | `TX_SENDING` to `TX_IDLE` | arbitration loss, end of data or end of frame |
| Receive | `RX_IDLE` to `RX_ACTIVE` | receive start |
| Receive | `RX_ACTIVE` to `RX_IDLE` | end of frame |

The buffer machine moves between its four states on three events:

- an arrival, which fills the bus side;
- an accepted swap, which moves the bus-side occupancy to the CPU side and empties the bus side;
- a CPU release, which empties the CPU side.

Top module: `frame_buf_status`

## Requirements
- R1: After reset the status word is 0x0000. Bits 15 to 5 always read 0.
- R2: Status bit 0 (transmit in progress) becomes 1 in the cycle after a transmit start. It returns to 0 in the cycle after an arbitration loss, an end of data or an end of frame. Terminating events that arrive while idle are ignored, so a start wins over them when both fall in the same cycle.
- R3: Status bit 1 (receive in progress) becomes 1 in the cycle after a receive start. It returns to 0 in the cycle after an end of frame.
- R4: An arrival is a frame-received pulse when `cfg_block` is 0, and a byte-received pulse when `cfg_block` is 1. The other kind of pulse has no effect. An arrival sets status bit 3 (bus buffer full). It raises `bus_buf_we` in the same cycle when the bus buffer is seen empty.
- R5: An arrival that sees the bus buffer full sets status bit 2 (message lost) in the next cycle.
- R6: During a lost-data arrival, `bus_buf_we` is 1 only when `cfg_overwrite` is 1.
- R7: A swap request while status bit 4 (CPU buffer full) is 0 raises `swap_ack` in the same cycle. In the next cycle, bit 4 takes the former value of bit 3, and bit 3 clears. A swap request while bit 4 is 1 gives no acknowledge and changes nothing.
- R8: A CPU release clears bit 4. In normal mode the same release also clears bit 2.
- R9: In block mode, bit 2 is cleared only by the software clear. The software clear also clears bit 2 in normal mode.
- R10: When a lost-data arrival and a clear of bit 2 fall in the same cycle, bit 2 ends up set.
- R11: A swap accepted in the same cycle as an arrival is processed first. The arrival sees an empty bus buffer, is written, does not set bit 2, and leaves bit 3 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_tx_start | input | 1 | Transmit of a frame or in-frame response begins |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_end_data | input | 1 | End of data detected |
| ev_end_frame | input | 1 | End of frame detected |
| ev_rx_start | input | 1 | Frame reception begins |
| ev_byte_rx | input | 1 | One byte received |
| ev_frame_rx | input | 1 | Complete frame received |
| swap_req | input | 1 | Request to exchange the bus and CPU buffers |
| cpu_release | input | 1 | CPU has consumed the CPU-side buffer |
| sw_clr_lost | input | 1 | Software clear of the message-lost flag |
| cfg_block | input | 1 | 1 selects byte-wise block mode, 0 selects frame-wise normal mode |
| cfg_overwrite | input | 1 | 1 lets arrivals replace an unread bus buffer |
| status | output | 16 | Status word: bit0 transmit, bit1 receive, bit2 lost, bit3 bus full, bit4 CPU full |
| bus_buf_we | output | 1 | Write enable for the bus-side buffer, same cycle as the arrival |
| swap_ack | output | 1 | Swap accepted this cycle |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is an accepted swap and an arrival. The bench fills the bus buffer while the CPU side is empty, then pulses the swap request and a byte pulse together. It judges the result on three things: the write enable and acknowledge in that same cycle, the lost flag staying low, and both full bits set in the next cycle.

The second pair is a lost-data arrival and a clear of the lost flag. Both the software clear and a normal-mode release are pulsed with a conflicting arrival, and the flag must end up set. A behavioural model checks every other cycle as well.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
    localparam int STAT_W   = 16;
    localparam int BIT_TIP  = 0;
    localparam int BIT_RIP  = 1;
    localparam int BIT_LOST = 2;
    localparam int BIT_BUSF = 3;
    localparam int BIT_CPUF = 4;
    localparam int USED_W   = 5;

    typedef enum logic {
        TX_IDLE,
        TX_SENDING
    } tx_state_e;

    typedef enum logic {
        RX_IDLE,
        RX_ACTIVE
    } rx_state_e;

    // bit 0 = bus side full, bit 1 = cpu side full
    typedef enum logic [1:0] {
        BUF_EMPTY = 2'b00,
        BUF_BUS   = 2'b01,
        BUF_CPU   = 2'b10,
        BUF_BOTH  = 2'b11
    } buf_state_e;
endpackage

// File: rtl/fbs_tx_fsm.sv
module fbs_tx_fsm
    import fbs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic arb_lost,
    input  logic end_data,
    input  logic end_frame,
    output logic busy
);
    tx_state_e state_q, state_d;
    logic      stop_any;

    assign stop_any = arb_lost | end_data | end_frame;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:    if (start)    state_d = TX_SENDING;
            TX_SENDING: if (stop_any) state_d = TX_IDLE;
            default:                  state_d = TX_IDLE;
        endcase
    end

    always_comb begin
        busy = (state_q == TX_SENDING);
    end

    AST_TIP_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (arb_lost || end_data || end_frame) |=> !busy); // R2
    AST_TIP_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start |=> busy); // R2
endmodule

// File: rtl/fbs_rx_fsm.sv
module fbs_rx_fsm
    import fbs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic end_frame,
    output logic busy
);
    rx_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:   if (start)     state_d = RX_ACTIVE;
            RX_ACTIVE: if (end_frame) state_d = RX_IDLE;
            default:                  state_d = RX_IDLE;
        endcase
    end

    always_comb begin
        busy = (state_q == RX_ACTIVE);
    end

    AST_RIP_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        busy && end_frame |=> !busy); // R3
endmodule

// File: rtl/fbs_buf_fsm.sv
module fbs_buf_fsm
    import fbs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic byte_rx,
    input  logic frame_rx,
    input  logic swap_req,
    input  logic cpu_release,
    input  logic sw_clr_lost,
    input  logic block_mode,
    input  logic overwrite,
    output logic bus_full,
    output logic cpu_full,
    output logic lost,
    output logic wr_en,
    output logic swap_ack
);
    buf_state_e state_q, state_d;
    logic       lost_q;
    logic       arrive, swap_go, seen_full;
    logic       bus_d, cpu_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUF_EMPTY;
            lost_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (arrive && seen_full)                    lost_q <= 1'b1;
            else if (sw_clr_lost || (!block_mode && cpu_release)) lost_q <= 1'b0;
        end
    end

    // occupancy decode
    always_comb begin
        unique case (state_q)
            BUF_EMPTY: begin bus_full = 1'b0; cpu_full = 1'b0; end
            BUF_BUS:   begin bus_full = 1'b1; cpu_full = 1'b0; end
            BUF_CPU:   begin bus_full = 1'b0; cpu_full = 1'b1; end
            BUF_BOTH:  begin bus_full = 1'b1; cpu_full = 1'b1; end
            default:   begin bus_full = 1'b0; cpu_full = 1'b0; end
        endcase
    end

    // swap is resolved before the arrival of the same cycle
    always_comb begin
        arrive    = block_mode ? byte_rx : frame_rx;
        swap_go   = swap_req && !cpu_full;
        seen_full = bus_full && !swap_go;
        bus_d     = arrive ? 1'b1 : (swap_go ? 1'b0 : bus_full);
        cpu_d     = swap_go ? bus_full : (cpu_release ? 1'b0 : cpu_full);
        state_d   = buf_state_e'({cpu_d, bus_d});
    end

    always_comb begin
        wr_en    = arrive && (!seen_full || overwrite);
        swap_ack = swap_go;
        lost     = lost_q;
    end

    AST_SWAP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        swap_ack |=> cpu_full == $past(bus_full)); // R7
    AST_SWAP_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        swap_req && cpu_full && !cpu_release |=> cpu_full); // R7
    AST_LOST_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost) |-> $past(bus_full)); // R5
    AST_LOST_STICKY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        lost && block_mode && !sw_clr_lost |=> lost); // R9
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        arrive && bus_full && !swap_ack && sw_clr_lost |=> lost); // R10
    AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !overwrite && arrive && bus_full && !swap_ack |-> !wr_en); // R6
endmodule

// File: rtl/frame_buf_status.sv
module frame_buf_status
    import fbs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ev_tx_start,
    input  logic        ev_arb_lost,
    input  logic        ev_end_data,
    input  logic        ev_end_frame,
    input  logic        ev_rx_start,
    input  logic        ev_byte_rx,
    input  logic        ev_frame_rx,
    input  logic        swap_req,
    input  logic        cpu_release,
    input  logic        sw_clr_lost,
    input  logic        cfg_block,
    input  logic        cfg_overwrite,
    output logic [15:0] status,
    output logic        bus_buf_we,
    output logic        swap_ack
);
    localparam int PAD_W = STAT_W - USED_W;

    logic tip, rip, lost, busf, cpuf;

    fbs_tx_fsm u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (ev_tx_start),
        .arb_lost  (ev_arb_lost),
        .end_data  (ev_end_data),
        .end_frame (ev_end_frame),
        .busy      (tip)
    );

    fbs_rx_fsm u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (ev_rx_start),
        .end_frame (ev_end_frame),
        .busy      (rip)
    );

    fbs_buf_fsm u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_rx     (ev_byte_rx),
        .frame_rx    (ev_frame_rx),
        .swap_req    (swap_req),
        .cpu_release (cpu_release),
        .sw_clr_lost (sw_clr_lost),
        .block_mode  (cfg_block),
        .overwrite   (cfg_overwrite),
        .bus_full    (busf),
        .cpu_full    (cpuf),
        .lost        (lost),
        .wr_en       (bus_buf_we),
        .swap_ack    (swap_ack)
    );

    always_comb begin
        status           = '0;
        status[BIT_TIP]  = tip;
        status[BIT_RIP]  = rip;
        status[BIT_LOST] = lost;
        status[BIT_BUSF] = busf;
        status[BIT_CPUF] = cpuf;
    end

    AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        status[STAT_W-1:USED_W] == {PAD_W{1'b0}}); // R1
endmodule

// File: tb/sim_frame_buf_status.sv
`timescale 1ns/1ps
module sim_frame_buf_status;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_s = 0, arb = 0, eod = 0, eof = 0, rx_s = 0, byt = 0, frm = 0;
    logic swp = 0, rel = 0, clr = 0, blk = 0, ovw = 0;
    logic [15:0] status;
    logic we, ack;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    bit m_tip, m_rip, m_lost, m_bus, m_cpu;
    bit e_we, e_ack;

    always #2.5 clk = ~clk;

    frame_buf_status u0 (
        .clk(clk), .rst_n(rst_n),
        .ev_tx_start(tx_s), .ev_arb_lost(arb), .ev_end_data(eod), .ev_end_frame(eof),
        .ev_rx_start(rx_s), .ev_byte_rx(byt), .ev_frame_rx(frm),
        .swap_req(swp), .cpu_release(rel), .sw_clr_lost(clr),
        .cfg_block(blk), .cfg_overwrite(ovw),
        .status(status), .bus_buf_we(we), .swap_ack(ack)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int model_word();
        return {11'd0, m_cpu, m_bus, m_lost, m_rip, m_tip};
    endfunction

    // one clock: compare outputs with the model, then advance the model
    task automatic cyc();
        bit arrive, swap_ok, seen;
        bit n_lost, n_cpu, n_bus;
        #1;
        arrive  = blk ? byt : frm;
        swap_ok = swp && !m_cpu;
        seen    = m_bus && !swap_ok;
        e_we    = arrive && (!seen || ovw);
        e_ack   = swap_ok;
        chk("R6 write enable", we, e_we);
        chk("R7 swap ack", ack, e_ack);
        chk("R1 status word", status, model_word());
        if (!m_tip) m_tip = tx_s; else if (arb || eod || eof) m_tip = 0;
        if (!m_rip) m_rip = rx_s; else if (eof) m_rip = 0;
        n_lost = m_lost;
        if (arrive && seen) n_lost = 1;
        else if (clr || (!blk && rel)) n_lost = 0;
        n_cpu = swap_ok ? m_bus : (rel ? 1'b0 : m_cpu);
        n_bus = arrive ? 1'b1 : (swap_ok ? 1'b0 : m_bus);
        m_lost = n_lost; m_cpu = n_cpu; m_bus = n_bus;
        @(negedge clk);
        {tx_s, arb, eod, eof, rx_s, byt, frm, swp, rel, clr} = '0;
    endtask

    initial begin
        #(5ns * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset word", status, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 word after release", status, 0);

        // R2: each terminating event
        tx_s = 1; cyc();
        chk("R2 tip set", status[0], 1);
        eof = 1; cyc();
        chk("R2 tip cleared by end of frame", status[0], 0);
        tx_s = 1; cyc(); arb = 1; cyc();
        chk("R2 tip cleared by arbitration loss", status[0], 0);
        tx_s = 1; cyc(); eod = 1; cyc();
        chk("R2 tip cleared by end of data", status[0], 0);
        tx_s = 1; arb = 1; cyc();
        chk("R2 start wins while idle", status[0], 1);
        eof = 1; cyc();

        // R3
        rx_s = 1; cyc();
        chk("R3 rip set", status[1], 1);
        cyc();
        chk("R3 rip holds", status[1], 1);
        eof = 1; cyc();
        chk("R3 rip cleared", status[1], 0);

        // R4: normal mode
        byt = 1; cyc();
        chk("R4 byte ignored in normal mode", status[3], 0);
        frm = 1; cyc();
        chk("R4 frame fills bus buffer", status[3], 1);
        // R5 and R6 without overwrite
        frm = 1; #1 chk("R6 dropped, no write", we, 0); cyc();
        chk("R5 lost set", status[2], 1);
        // R7
        swp = 1; cyc();
        chk("R7 cpu full after swap", status[4:3], 2'b10);
        frm = 1; cyc();
        swp = 1; #1 chk("R7 no ack when cpu full", ack, 0); cyc();
        chk("R7 state unchanged", status[4:3], 2'b11);
        // R8: release clears cpu and lost in normal mode
        rel = 1; cyc();
        chk("R8 cpu cleared", status[4], 0);
        chk("R8 lost cleared in normal mode", status[2], 0);

        // R6 with overwrite
        ovw = 1;
        frm = 1; #1 chk("R6 overwrite writes", we, 1); cyc();
        chk("R5 lost set with overwrite", status[2], 1);
        clr = 1; cyc();
        chk("R9 software clear in normal mode", status[2], 0);
        swp = 1; cyc(); rel = 1; cyc();

        // block mode
        blk = 1; ovw = 0;
        frm = 1; cyc();
        chk("R4 frame ignored in block mode", status[3], 0);
        byt = 1; cyc(); byt = 1; cyc();
        chk("R5 lost set per byte", status[2], 1);
        swp = 1; cyc(); rel = 1; cyc();
        chk("R9 release leaves lost in block mode", status[2], 1);
        clr = 1; cyc();
        chk("R9 software clear in block mode", status[2], 0);

        // R10: set wins over software clear
        byt = 1; cyc();
        byt = 1; clr = 1; cyc();
        chk("R10 set beats software clear", status[2], 1);
        clr = 1; cyc();
        blk = 0;
        frm = 1; rel = 1; cyc();
        chk("R10 set beats release clear", status[2], 1);
        clr = 1; cyc();

        // R11: swap and arrival together
        blk = 1;
        swp = 1; cyc(); rel = 1; cyc();
        byt = 1; cyc();
        swp = 1; byt = 1;
        #1 chk("R11 ack", ack, 1);
        chk("R11 write", we, 1);
        cyc();
        chk("R11 both full", status[4:3], 2'b11);
        chk("R11 no lost", status[2], 0);

        repeat (4) cyc();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule